// File: doc/BRIEF.md
# Overlapping Dual-Pattern Serial Sequence Detector

This block watches a serial bit stream, one bit per clock, and raises a flag whenever the three most recent bits form either the pattern 110 or the pattern 101. The first bit in each pattern is the oldest, and the last bit is the one just received. Matches may share bits. In the stream 1101, a flag follows the third bit (110) and another follows the fourth bit (101).

One minimal set of six states serves both patterns. Two outputs come from that set. `hit_moore` is a flag decoded from the state register only, so it rises in the cycle after the completing bit. `hit_mealy` is a combinational function of the state and the present input, so it rises during the cycle in which the completing bit is on `bit_in`. Because both outputs are available, the two output styles can be compared directly.

A parameter chooses between two ways of storing the state: a dense binary code or one flop per state. Both give the same behaviour at the ports.

Top module: `seqdet_dual`

## Requirements
- R1: `rst` is synchronous and active high. At a rising clock edge where `rst` is 1, the machine enters its empty-history state, and `hit_moore` is 0 after that edge. While `rst` rises between edges, neither output changes before the next edge. In the empty-history state, `hit_mealy` is 0 for either input value.
- R2: Bits received before a reset never count toward a match. After reset, a flag needs three fresh bits.
- R3: `hit_mealy` is 1 when the current `bit_in` is 0 and the two bits before it were 1 then 1 (pattern 110).
- R4: `hit_mealy` is 1 when the current `bit_in` is 1 and the two bits before it were 1 then 0 (pattern 101).
- R5: Overlapping matches are all reported. A completing bit can also be the first or second bit of the next match. For example, 11011 flags on the third and fourth bits, and 110101 flags on the third, fourth and sixth bits.
- R6: `hit_moore` depends on the state only. It equals the value `hit_mealy` had just before the previous rising edge, and it stays steady when `bit_in` changes within a cycle.
- R7: `hit_mealy` is combinational. It is valid in the same cycle that the completing bit is present on `bit_in`.
- R8: Every other three-bit window gives 0 on both outputs. These windows are 000, 001, 010, 011, 100 and 111.
- R9: `ONE_HOT_STATE` = 0 (binary storage) and `ONE_HOT_STATE` = 1 (one flop per state) give identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state is updated on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the empty-history state |
| bit_in | input | 1 | Serial data bit, one per clock |
| hit_moore | output | 1 | Registered match flag, one cycle after the completing bit |
| hit_mealy | output | 1 | Combinational match flag, during the completing bit's cycle |

## Verification
The machine's memory is only two bits deep, so a wrong state produces a visible error quickly. `hit_mealy` shows a wrong flag, or a missing one, within the next two input bits. `hit_moore` shows the same error one cycle later. The stimulus stream passes through every state with both input values, including chains of overlapping matches and a reset that cuts off a partial match. As a result, any misrouted transition reaches a port within a few cycles. Two instances, one per storage variant, are compared against the same expected values.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

   // Names describe the last bits seen (newest on the right).
   typedef enum logic [2:0] {
      ST_EMPTY   = 3'd0,   // no useful history
      ST_ONE     = 3'd1,   // ends in 1 (not 11, not a 101 hit)
      ST_ONEONE  = 3'd2,   // ends in 11
      ST_ONEZERO = 3'd3,   // ends in 10 (not a 110 hit)
      ST_HIT110  = 3'd4,   // just completed 110, ends in 10
      ST_HIT101  = 3'd5    // just completed 101, ends in 01
   } seq_state_t;

   localparam int NUM_STATES = 6;
   localparam int STATE_BITS = $clog2(NUM_STATES);

endpackage

// File: rtl/seqdet_step.sv
module seqdet_step
   import seqdet_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  seq_state_t cur,
   input  logic       bit_in,
   output seq_state_t nxt
);

   always_comb begin
      unique case (cur)
         ST_EMPTY:   nxt = bit_in ? ST_ONE    : ST_EMPTY;
         ST_ONE:     nxt = bit_in ? ST_ONEONE : ST_ONEZERO;
         ST_ONEONE:  nxt = bit_in ? ST_ONEONE : ST_HIT110;
         ST_ONEZERO: nxt = bit_in ? ST_HIT101 : ST_EMPTY;
         ST_HIT110:  nxt = bit_in ? ST_HIT101 : ST_EMPTY;
         ST_HIT101:  nxt = bit_in ? ST_ONEONE : ST_ONEZERO;
         default:    nxt = ST_EMPTY;
      endcase
   end

   // R3: a 110 hit state is only reached after a 0 was sampled
   a_r3_hit110_after_zero: assert property (@(posedge clk) disable iff (rst)
      (cur == ST_HIT110) |-> !$past(bit_in))
      else $error("a_r3_hit110_after_zero");

   // R4: a 101 hit state is only reached after a 1 was sampled
   a_r4_hit101_after_one: assert property (@(posedge clk) disable iff (rst)
      (cur == ST_HIT101) |-> $past(bit_in))
      else $error("a_r4_hit101_after_one");

   // R5: two consecutive 1s before the current bit imply the 11 state
   a_r5_oneone_tracks_input: assert property (@(posedge clk) disable iff (rst)
      (cur == ST_ONEONE) |-> ($past(bit_in) && $past(cur) != ST_EMPTY))
      else $error("a_r5_oneone_tracks_input");

endmodule

// File: rtl/seqdet_hold.sv
module seqdet_hold
   import seqdet_pkg::*;
#(
   parameter bit ONE_HOT_STATE = 1'b0
)
(
   input  logic       clk,
   input  logic       rst,
   input  seq_state_t nxt,
   output seq_state_t cur
);

   generate
      if (ONE_HOT_STATE) begin : g_onehot
         logic [NUM_STATES-1:0] oh_q;

         always_ff @(posedge clk) begin
            if (rst) oh_q <= NUM_STATES'(1);
            else     oh_q <= NUM_STATES'(1) << nxt;
         end

         always_comb begin
            cur = ST_EMPTY;
            for (int k = 0; k < NUM_STATES; k++) begin
               if (oh_q[k]) cur = seq_state_t'(STATE_BITS'(k));
            end
         end

         // R9: one-hot storage always holds exactly one active flop
         a_r9_onehot_legal: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> ($countones(oh_q) == 1))
            else $error("a_r9_onehot_legal");
      end else begin : g_binary
         seq_state_t bin_q;

         always_ff @(posedge clk) begin
            if (rst) bin_q <= ST_EMPTY;
            else     bin_q <= nxt;
         end

         assign cur = bin_q;
      end
   endgenerate

endmodule

// File: rtl/seqdet_flags.sv
module seqdet_flags
   import seqdet_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  seq_state_t cur,
   input  logic       bit_in,
   output logic       hit_moore,
   output logic       hit_mealy
);

   assign hit_moore = (cur == ST_HIT110) || (cur == ST_HIT101);

   assign hit_mealy = ((cur == ST_ONEONE) && !bit_in)
                   || (((cur == ST_ONEZERO) || (cur == ST_HIT110)) && bit_in);

   // R6: the registered flag is the earlier cycle's combinational flag
   a_r6_moore_follows_mealy: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (hit_moore == $past(hit_mealy)))
      else $error("a_r6_moore_follows_mealy");

   // R1: the cycle after reset releases, the registered flag is low
   a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !hit_moore)
      else $error("a_r1_clear_after_reset");

   // R2: with no history, no input can complete a match
   a_r2_empty_never_flags: assert property (@(posedge clk) disable iff (rst)
      (cur == ST_EMPTY || cur == ST_ONE) |-> !hit_mealy)
      else $error("a_r2_empty_never_flags");

endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
   import seqdet_pkg::*;
#(
   parameter bit ONE_HOT_STATE = 1'b0
)
(
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic hit_moore,
   output logic hit_mealy
);

   generate
      if (NUM_STATES != 6 || STATE_BITS < 3) begin : g_bad_cfg
         $error("seqdet_dual: state set must be six states in three bits");
      end
   endgenerate

   seq_state_t cur_st;
   seq_state_t nxt_st;

   seqdet_step u_step (
      .clk    (clk),
      .rst    (rst),
      .cur    (cur_st),
      .bit_in (bit_in),
      .nxt    (nxt_st)
   );

   seqdet_hold #(.ONE_HOT_STATE(ONE_HOT_STATE)) u_hold (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   seqdet_flags u_flags (
      .clk       (clk),
      .rst       (rst),
      .cur       (cur_st),
      .bit_in    (bit_in),
      .hit_moore (hit_moore),
      .hit_mealy (hit_mealy)
   );

endmodule

// File: tb/test_seqdet_dual.sv
module test_seqdet_dual;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC       = 24;

   // {bit_in, expected hit_mealy}; entry 0 is the first bit after reset
   localparam logic [1:0] VEC [NVEC] = '{
      2'b10, 2'b10, 2'b01, 2'b11, 2'b00, 2'b11, 2'b10, 2'b10,
      2'b01, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b10, 2'b10,
      2'b01, 2'b11, 2'b10, 2'b01, 2'b11, 2'b00, 2'b00, 2'b00
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_in = 1'b0;
   logic moore_b, mealy_b, moore_h, mealy_h;
   int   n_checks = 0;
   int   n_err = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   seqdet_dual #(.ONE_HOT_STATE(1'b0)) i_seqdet_dual (
      .clk (clk), .rst (rst), .bit_in (bit_in),
      .hit_moore (moore_b), .hit_mealy (mealy_b)
   );

   seqdet_dual #(.ONE_HOT_STATE(1'b1)) i_seqdet_dual_oh (
      .clk (clk), .rst (rst), .bit_in (bit_in),
      .hit_moore (moore_h), .hit_mealy (mealy_h)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // R9: both storage variants are held to the same expectation
   task automatic chk_moore(input string tag, input logic exp);
      chk({tag, " moore binary"}, moore_b, exp);
      chk({tag, " moore onehot R9"}, moore_h, exp);
   endtask

   task automatic chk_mealy(input string tag, input logic exp);
      chk({tag, " mealy binary"}, mealy_b, exp);
      chk({tag, " mealy onehot R9"}, mealy_h, exp);
   endtask

   task automatic drive(input logic b);
      @(negedge clk);
      bit_in = b;
      #1;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_moore("R1 reset", 1'b0);
      chk_mealy("R1 reset input0", 1'b0);
      bit_in = 1'b1;
      #1;
      chk_mealy("R1 reset input1", 1'b0);
      bit_in = 1'b0;
      rst = 1'b0;

      // R3 R4 R5 R7 R8: stream walk; R6 registered flag lags one cycle
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         if (i > 0) chk_moore("R6 lag", VEC[i-1][0]);
         bit_in = VEC[i][1];
         #1;
         chk_mealy("R3 R4 R5 R7 R8 stream", VEC[i][0]);
         if (i > 0) chk_moore("R6 steady on input change", VEC[i-1][0]);
      end
      @(negedge clk);
      chk_moore("R6 lag tail", VEC[NVEC-1][0]);

      // R1 R2: reset that cuts off an overlap in progress
      drive(1'b1);
      drive(1'b1);
      drive(1'b0);
      chk_mealy("R3 before reset", 1'b1);
      @(negedge clk);
      chk_moore("R6 before reset", 1'b1);
      rst = 1'b1;
      bit_in = 1'b1;
      #1;
      chk_moore("R1 synchronous hold", 1'b1);
      @(negedge clk);
      chk_moore("R1 after edge", 1'b0);
      rst = 1'b0;
      #1;
      chk_mealy("R2 history cleared", 1'b0);
      drive(1'b0);
      chk_mealy("R2 two fresh bits", 1'b0);
      drive(1'b1);
      chk_mealy("R4 after reset", 1'b1);
      @(negedge clk);
      chk_moore("R6 after reset", 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule